// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block steers a multi-cycle datapath from a small internal control store. A 4-bit micro-program counter selects one microword per clock. Each microword carries 19 datapath control bits and a 2-bit sequencing code. The sequencing code picks the next micro-address from one of four sources: the current address plus one, the start word, or one of two dispatch tables. Both dispatch tables are indexed by the instruction opcode.

Each instruction starts with a common fetch word. A first dispatch then sends it to the arithmetic, memory, branch or jump routine. Memory instructions take a second dispatch after the address computation, which separates stores from loads. The surrounding datapath must hold `opcode_i` steady from the fetch word to the end of the instruction. The opcode is read combinationally whenever a dispatch is taken. The microprogram is fixed logic, so it cannot be changed at run time.

Top module: `ucode_ctrl`

## Requirements
- R1: When `rst_ni` goes low, `upc_o` becomes 0 at once, without waiting for a clock edge, and `ctrl_o` shows the fetch word. The fetch word sets bits 0, 3, 4, 8 and 9 and clears all other bits.
- R2: `ctrl_o` always equals the microword at the address on `upc_o`, using this bit map:
  - bit 0: PC increment
  - bit 1: branch PC load
  - bit 2: jump PC load
  - bit 3: instruction register load
  - bit 4: instruction memory read
  - bit 5: data memory read
  - bit 6: data memory write
  - bit 7: address register load
  - bit 8: A load
  - bit 9: B load
  - bit 10: rd write
  - bit 11: rt write
  - bit 12: write-back from memory
  - bit 13: ALU immediate operand
  - bit 14: ALU function from the instruction
  - bit 15: ALU add
  - bit 16: ALU subtract
  - bit 17: result register load
  - bit 18: memory data register load

  Bits 5 and 6 are never both set.
- R3: With opcode 000000 (register class), `upc_o` steps 0, 1, 2, 0. Word 1 sets bits 14 and 17. Word 2 sets bit 10.
- R4: With opcode 101011 (store), `upc_o` steps 0, 3, 4, 0. Word 3 sets bits 7, 13 and 15. Word 4 sets bit 6.
- R5: With opcode 100011 (load), `upc_o` steps 0, 3, 5, 6, 0. Word 5 sets bits 5 and 18. Word 6 sets bits 11 and 12.
- R6: With opcode 000100 (branch), `upc_o` steps 0, 7, 0. Word 7 sets bits 1 and 16.
- R7: With opcode 000010 (jump), `upc_o` steps 0, 8, 0. Word 8 sets bit 2.
- R8: An opcode that is absent from the first dispatch table makes the dispatch return address 0, so `upc_o` stays on the fetch word.
- R9: An opcode on `opcode_i` that is neither load nor store when word 3 executes makes the second dispatch return address 0.
- R10: `upc_o` never exceeds 8. Microwords 9 to 15 hold all-zero controls with reset sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Instruction opcode, held for the whole instruction |
| ctrl_o | output | 19 | Datapath control word of the current microword |
| upc_o | output | 4 | Current micro-program counter |

## Verification
The assertions check the following on every cycle:
- a next code advances the micro-PC by one;
- a reset code returns it to 0;
- each dispatch lands only on one of its legal targets;
- the micro-PC stays within the used words;
- memory read and write are never both set.

The bench scenarios are needed for the rest. They show that each of the five opcodes walks the correct word order with the correct control bits. They also show that unknown opcodes fall back to fetch, both at the first dispatch and at the second when the opcode changes mid-instruction. Finally, they show that an asynchronous reset in the middle of a routine returns the sequencer to fetch.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int UPC_W  = 4;
  localparam int CTRL_W = 19;
  localparam int OP_W   = 6;

  typedef enum logic [1:0] {
    SEQ_NEXT = 2'b00,
    SEQ_RST  = 2'b01,
    SEQ_DSP1 = 2'b10,
    SEQ_DSP2 = 2'b11
  } seq_e;

  // control bit positions
  localparam int B_PC_INC   = 0;
  localparam int B_PC_BR    = 1;
  localparam int B_PC_JMP   = 2;
  localparam int B_IR_LD    = 3;
  localparam int B_IMEM_RD  = 4;
  localparam int B_DMEM_RD  = 5;
  localparam int B_DMEM_WR  = 6;
  localparam int B_ADDR_LD  = 7;
  localparam int B_A_LD     = 8;
  localparam int B_B_LD     = 9;
  localparam int B_RD_WR    = 10;
  localparam int B_RT_WR    = 11;
  localparam int B_WB_MEM   = 12;
  localparam int B_ALU_IMM  = 13;
  localparam int B_ALU_FUNC = 14;
  localparam int B_ALU_ADD  = 15;
  localparam int B_ALU_SUB  = 16;
  localparam int B_RES_LD   = 17;
  localparam int B_MDR_LD   = 18;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OP_STORE = 6'b101011;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'b000010;

  localparam logic [UPC_W-1:0] UA_FETCH  = 4'd0;
  localparam logic [UPC_W-1:0] UA_ARITH  = 4'd1;
  localparam logic [UPC_W-1:0] UA_RD_WB  = 4'd2;
  localparam logic [UPC_W-1:0] UA_MADDR  = 4'd3;
  localparam logic [UPC_W-1:0] UA_STORE  = 4'd4;
  localparam logic [UPC_W-1:0] UA_LOAD   = 4'd5;
  localparam logic [UPC_W-1:0] UA_RT_WB  = 4'd6;
  localparam logic [UPC_W-1:0] UA_BRANCH = 4'd7;
  localparam logic [UPC_W-1:0] UA_JUMP   = 4'd8;
  localparam logic [UPC_W-1:0] UA_LAST   = UA_JUMP;
endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int CW = CTRL_W
) (
  input  logic [AW-1:0] addr_i,
  output logic [CW-1:0] ctrl_o,
  output seq_e          seq_o
);
  always_comb begin
    ctrl_o = '0;
    seq_o  = SEQ_RST;
    unique case (addr_i)
      UA_FETCH: begin
        ctrl_o[B_PC_INC]  = 1'b1;
        ctrl_o[B_IR_LD]   = 1'b1;
        ctrl_o[B_IMEM_RD] = 1'b1;
        ctrl_o[B_A_LD]    = 1'b1;
        ctrl_o[B_B_LD]    = 1'b1;
        seq_o = SEQ_DSP1;
      end
      UA_ARITH: begin
        ctrl_o[B_ALU_FUNC] = 1'b1;
        ctrl_o[B_RES_LD]   = 1'b1;
        seq_o = SEQ_NEXT;
      end
      UA_RD_WB:  ctrl_o[B_RD_WR] = 1'b1;
      UA_MADDR: begin
        ctrl_o[B_ADDR_LD] = 1'b1;
        ctrl_o[B_ALU_IMM] = 1'b1;
        ctrl_o[B_ALU_ADD] = 1'b1;
        seq_o = SEQ_DSP2;
      end
      UA_STORE:  ctrl_o[B_DMEM_WR] = 1'b1;
      UA_LOAD: begin
        ctrl_o[B_DMEM_RD] = 1'b1;
        ctrl_o[B_MDR_LD]  = 1'b1;
        seq_o = SEQ_NEXT;
      end
      UA_RT_WB: begin
        ctrl_o[B_RT_WR]  = 1'b1;
        ctrl_o[B_WB_MEM] = 1'b1;
      end
      UA_BRANCH: begin
        ctrl_o[B_PC_BR]   = 1'b1;
        ctrl_o[B_ALU_SUB] = 1'b1;
      end
      UA_JUMP:   ctrl_o[B_PC_JMP] = 1'b1;
      default: begin
        ctrl_o = '0;
        seq_o  = SEQ_RST;
      end
    endcase
  end
endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
#(
  parameter int TABLE = 1,
  parameter int OW    = OP_W,
  parameter int AW    = UPC_W
) (
  input  logic [OW-1:0] opcode_i,
  output logic [AW-1:0] addr_o
);
  generate
    if (TABLE == 1) begin : g_tab1
      always_comb begin
        unique case (opcode_i)
          OP_RTYPE:         addr_o = UA_ARITH;
          OP_LOAD, OP_STORE: addr_o = UA_MADDR;
          OP_BEQ:           addr_o = UA_BRANCH;
          OP_JUMP:          addr_o = UA_JUMP;
          default:          addr_o = UA_FETCH;
        endcase
      end
    end else begin : g_tab2
      always_comb begin
        unique case (opcode_i)
          OP_STORE: addr_o = UA_STORE;
          OP_LOAD:  addr_o = UA_LOAD;
          default:  addr_o = UA_FETCH;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_e          seq_i,
  input  logic [AW-1:0] dsp1_i,
  input  logic [AW-1:0] dsp2_i,
  output logic [AW-1:0] upc_o
);
  logic [AW-1:0] upc_q, upc_d;

  always_comb begin
    unique case (seq_i)
      SEQ_NEXT: upc_d = upc_q + AW'(1);
      SEQ_RST:  upc_d = '0;
      SEQ_DSP1: upc_d = dsp1_i;
      SEQ_DSP2: upc_d = dsp2_i;
      default:  upc_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;

  assert_next_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i == SEQ_NEXT) |=> (upc_q == $past(upc_q) + AW'(1)));
  assert_reset_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_i == SEQ_RST) |=> (upc_q == '0));
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int AW = UPC_W,
  parameter int CW = CTRL_W,
  parameter int OW = OP_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] opcode_i,
  output logic [CW-1:0] ctrl_o,
  output logic [AW-1:0] upc_o
);
  logic [AW-1:0] upc, dsp1_addr, dsp2_addr;
  seq_e          seq;

  ucode_rom #(.AW(AW), .CW(CW)) u_rom (
    .addr_i (upc),
    .ctrl_o (ctrl_o),
    .seq_o  (seq)
  );

  ucode_dispatch #(.TABLE(1), .OW(OW), .AW(AW)) u_dsp1 (
    .opcode_i (opcode_i),
    .addr_o   (dsp1_addr)
  );

  ucode_dispatch #(.TABLE(2), .OW(OW), .AW(AW)) u_dsp2 (
    .opcode_i (opcode_i),
    .addr_o   (dsp2_addr)
  );

  ucode_seq #(.AW(AW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seq_i  (seq),
    .dsp1_i (dsp1_addr),
    .dsp2_i (dsp2_addr),
    .upc_o  (upc)
  );

  assign upc_o = upc;

  assert_upc_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upc <= UA_LAST);
  assert_mem_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_o[B_DMEM_RD] && ctrl_o[B_DMEM_WR]));
  assert_dsp1_target_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DSP1) |=> (upc == UA_FETCH || upc == UA_ARITH || upc == UA_MADDR
                           || upc == UA_BRANCH || upc == UA_JUMP));
  assert_dsp2_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq == SEQ_DSP2) |=> (upc == UA_FETCH || upc == UA_STORE || upc == UA_LOAD));
  assert_fetch_after_reset_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (upc == UA_FETCH));
endmodule

// File: tb/ucode_ctrl_test.sv
module ucode_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  opcode_i = 6'd0;
  logic [18:0] ctrl_o;
  logic [3:0]  upc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_upc = 4'd0;

  ucode_ctrl uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .ctrl_o   (ctrl_o),
    .upc_o    (upc_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [18:0] word_of(input logic [3:0] a);
    logic [18:0] w = '0;
    case (a)
      4'd0: begin w[0]=1; w[3]=1; w[4]=1; w[8]=1; w[9]=1; end
      4'd1: begin w[14]=1; w[17]=1; end
      4'd2: w[10]=1;
      4'd3: begin w[7]=1; w[13]=1; w[15]=1; end
      4'd4: w[6]=1;
      4'd5: begin w[5]=1; w[18]=1; end
      4'd6: begin w[11]=1; w[12]=1; end
      4'd7: begin w[1]=1; w[16]=1; end
      4'd8: w[2]=1;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [3:0] next_of(input logic [3:0] a, input logic [5:0] op);
    case (a)
      4'd0: case (op)
              6'b000000: return 4'd1;
              6'b100011, 6'b101011: return 4'd3;
              6'b000100: return 4'd7;
              6'b000010: return 4'd8;
              default: return 4'd0;
            endcase
      4'd1: return 4'd2;
      4'd3: case (op)
              6'b101011: return 4'd4;
              6'b100011: return 4'd5;
              default: return 4'd0;
            endcase
      4'd5: return 4'd6;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      4'd1, 4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    string t = (tag != "") ? tag : req_of(exp_upc);
    check(upc_o == exp_upc, t, 32'(upc_o), 32'(exp_upc));
    check(ctrl_o == word_of(exp_upc), "R2", 32'(ctrl_o), 32'(word_of(exp_upc)));
    check(upc_o <= 4'd8, "R10", 32'(upc_o), 32'd8);
    check(!(ctrl_o[5] && ctrl_o[6]), "R2", 32'(ctrl_o[6:5]), 32'd0);
  endtask

  task automatic step(input logic [5:0] op, input string tag);
    logic [3:0] nxt;
    opcode_i = op;
    nxt = next_of(exp_upc, op);
    @(posedge clk_i);
    @(negedge clk_i);
    exp_upc = nxt;
    compare(tag);
  endtask

  task automatic run_instr(input logic [5:0] op);
    int n = 0;
    do begin
      step(op, "");
      n++;
    end while (exp_upc != 4'd0 && n < 8);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [5:0] cur_op;
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    repeat (2) @(negedge clk_i);
    exp_upc = 4'd0;
    compare("R1");
    rst_ni = 1'b1;

    // directed per opcode
    run_instr(6'b000000);
    run_instr(6'b101011);
    run_instr(6'b100011);
    run_instr(6'b000100);
    run_instr(6'b000010);

    // R8 unknown opcode stays at fetch
    step(6'b111111, "R8");
    step(6'b010101, "R8");

    // R9 opcode changes to non-memory at second dispatch
    step(6'b101011, "R4");
    step(6'b000000, "R9");
    step(6'b100011, "R5");
    step(6'b000100, "R9");

    // R1 asynchronous reset mid-routine
    step(6'b100011, "R5");
    step(6'b100011, "R5");
    #1 rst_ni = 1'b0;
    #1;
    exp_upc = 4'd0;
    compare("R1");
    @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;

    // constrained random
    cur_op = 6'd0;
    for (int i = 0; i < 3000; i++) begin
      if (exp_upc == 4'd0) begin
        case ($urandom_range(0, 5))
          0: cur_op = 6'b000000;
          1: cur_op = 6'b100011;
          2: cur_op = 6'b101011;
          3: cur_op = 6'b000100;
          4: cur_op = 6'b000010;
          default: cur_op = 6'($urandom());
        endcase
      end else if ($urandom_range(0, 9) == 0) begin
        cur_op = 6'($urandom());
      end
      step(cur_op, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule